// File: doc/BRIEF.md
# Multi-Mode Coefficient Memory Loader

This block fills a coefficient store arranged as six banks of 108 words of 24 bits, each word carrying the two 12-bit coefficients of a pair of taps. A hold input resets the loader. When that input falls, a 7-bit setup word is captured, and two of its bits choose how the store is filled. Parallel mode takes one byte per clock edge. Processor mode takes one byte per pulse of an asynchronous write strobe. Serial mode takes one bit per falling strobe edge and walks the entire store in a fixed order.

Byte modes build each 24-bit word from two staging bytes and a final byte that commits the word to a bank. Serial mode shifts bits into a 24-bit word and writes it to an internal bank/location counter. After the last location of the last bank, serial mode raises a completion flag and enables run mode by itself. The write port toward the RAM is a fire-and-forget stream with no ready signal, because the RAM takes one write every cycle and never pushes back. A one-cycle pulse on a bank enable is the valid, and address and data are meaningful only during that pulse.

Top module: `coef_loader`

## Requirements
- R1: While `cfg_hold` is high, no bank write occurs, `run_en` is low, the serial progress is cleared, and both staging bytes are cleared to zero. On the clock where `cfg_hold` is seen low after being high, `din[6:0]` is stored as the setup word, and that clock also performs no write. After reset the setup word is zero.
- R2: In parallel mode (setup bits 6..5 = 01), every rising edge that samples `wr_n` and `ld_sel_n` both low handles one byte. Bytes on back-to-back edges are all taken.
- R3: `addr[9:7]` chooses the target of a byte. 110 loads the low staging byte and 111 loads the middle staging byte, whatever the value of `addr[6:0]`. Codes 000 to 101 write bank 0 to 5 at location `addr[6:0]` with the data {`din`, middle staging byte, low staging byte}. Staging bytes keep their values across bank writes. `mem_we` is one-hot during a write and zero otherwise.
- R4: A bank write whose location is 108 or more is dropped, and no enable is pulsed.
- R5: In processor mode (setup bits 6..5 = 10), each falling edge of `wr_n`, seen through a two-flop synchroniser while `ld_sel_n` is low, handles exactly one byte, however long the strobe stays low. Address and data must be held while the strobe is low. A strobe while `ld_sel_n` is high is ignored.
- R6: `run_en` is registered one clock after its inputs. In parallel mode it is low while `wr_n` and `ld_sel_n` are both low and high otherwise. In processor mode it follows `ld_sel_n`. In serial mode it equals the completion flag.
- R7: In serial mode (setup bits 6..5 = 00), each synchronised falling edge of `wr_n` while `ld_sel_n` is low takes `din[7]` as the next bit, MSB first. Every 24 bits form one word. Words go to bank 0 location 0 first, then the location increments, and after location 107 the count moves to location 0 of the next bank. Edges while `ld_sel_n` is high are not counted.
- R8: After 15552 serial bits, `serial_done` goes high and stays high until the next configure, `run_en` goes high, and further strobes cause no writes.
- R9: In the reserved mode (setup bits 6..5 = 11), no byte or bit is accepted and `run_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_hold | input | 1 | Loader reset while high; falling edge captures the setup word |
| ld_sel_n | input | 1 | Device select for loading, active low |
| wr_n | input | 1 | Write strobe, active low (synchronous in parallel mode, asynchronous otherwise) |
| din | input | 8 | Byte data; bit 7 is the serial bit; bits 6..0 form the setup word |
| addr | input | 10 | Target select [9:7] and location [6:0] |
| mem_we | output | 6 | One-hot bank write enables, one-cycle pulse |
| mem_addr | output | 7 | RAM location for the write |
| mem_wdata | output | 24 | RAM word for the write |
| run_en | output | 1 | Run mode enable |
| serial_done | output | 1 | Serial fill complete |

## Verification
A wrong staging byte or serial shift position shows up in the data of the very next bank write, which lands two to three clocks after the byte or bit that commits it. A wrong serial bank/location counter puts a write at the wrong address at the next 24-bit boundary. It also shifts the moment `serial_done` rises, which is visible only after the full fill of about 62,000 clocks. A strobe detector that fires more than once per pulse produces an extra enable pulse within three clocks, and the write scoreboard reports it as an unexpected write.

// File: rtl/coef_ld_pkg.sv
package coef_ld_pkg;
  typedef enum logic [1:0] {
    LM_SERIAL   = 2'b00,
    LM_PARALLEL = 2'b01,
    LM_PROC     = 2'b10,
    LM_RSVD     = 2'b11
  } load_mode_e;

  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_STG_LO = 3'b110;
  localparam logic [SEL_W-1:0] SEL_STG_HI = 3'b111;
endpackage

// File: rtl/coef_ld_fall_det.sv
module coef_ld_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], async_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/coef_ld_serial.sv
module coef_ld_serial #(
  parameter int unsigned NUM_BANK = 6,
  parameter int unsigned NUM_LOC  = 108,
  parameter int unsigned WORD_W   = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        bit_en,
  input  logic                        bit_in,
  output logic                        word_vld,
  output logic [WORD_W-1:0]           word,
  output logic [$clog2(NUM_BANK)-1:0] bank,
  output logic [$clog2(NUM_LOC)-1:0]  loc,
  output logic                        done
);
  localparam int unsigned CNT_W  = $clog2(WORD_W);
  localparam int unsigned BANK_W = $clog2(NUM_BANK);
  localparam int unsigned LOC_W  = $clog2(NUM_LOC);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic last_bit, last_loc, last_bank;

  assign last_bit  = (bit_cnt == CNT_W'(WORD_W - 1));
  assign last_loc  = (loc == LOC_W'(NUM_LOC - 1));
  assign last_bank = (bank == BANK_W'(NUM_BANK - 1));
  assign word_vld  = bit_en & last_bit;
  assign word      = {shreg[WORD_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; bit_cnt <= '0; loc <= '0; bank <= '0; done <= 1'b0;
    end else if (clr) begin
      shreg <= '0; bit_cnt <= '0; loc <= '0; bank <= '0; done <= 1'b0;
    end else if (bit_en) begin
      shreg <= {shreg[WORD_W-2:0], bit_in};
      if (last_bit) begin
        bit_cnt <= '0;
        if (last_loc) begin
          loc <= '0;
          if (last_bank) done <= 1'b1;
          else           bank <= bank + 1'b1;
        end else begin
          loc <= loc + 1'b1;
        end
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done); // R8
  AST_SER_TARGET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> (loc < LOC_W'(NUM_LOC) && bank < BANK_W'(NUM_BANK))); // R7
endmodule

// File: rtl/coef_loader.sv
module coef_loader
  import coef_ld_pkg::*;
#(
  parameter int unsigned NUM_BANK    = 6,
  parameter int unsigned NUM_LOC     = 108,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_hold,
  input  logic                                 ld_sel_n,
  input  logic                                 wr_n,
  input  logic [BYTE_W-1:0]                    din,
  input  logic [SEL_W+$clog2(NUM_LOC)-1:0]     addr,
  output logic [NUM_BANK-1:0]                  mem_we,
  output logic [$clog2(NUM_LOC)-1:0]           mem_addr,
  output logic [3*BYTE_W-1:0]                  mem_wdata,
  output logic                                 run_en,
  output logic                                 serial_done
);
  localparam int unsigned LOC_W  = $clog2(NUM_LOC);
  localparam int unsigned WORD_W = 3 * BYTE_W;
  localparam int unsigned BANK_W = $clog2(NUM_BANK);

  // setup word capture on the falling edge of the hold input
  logic       cfg_q, cfg_fall, busy;
  logic [6:0] cfg_word;
  load_mode_e mode;

  assign cfg_fall = cfg_q & ~cfg_hold;
  assign busy     = cfg_hold | cfg_fall;
  assign mode     = load_mode_e'(cfg_word[6:5]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= 1'b0;
      cfg_word <= '0;
    end else begin
      cfg_q <= cfg_hold;
      if (cfg_fall) cfg_word <= din[6:0];
    end
  end

  // strobe synchroniser, shared by processor and serial modes
  logic stb_fall;
  coef_ld_fall_det #(.STAGES(SYNC_STAGES)) u_stb (
    .clk(clk), .rst_n(rst_n), .async_n(wr_n), .fall(stb_fall)
  );

  // byte path
  logic [SEL_W-1:0] dest;
  logic [LOC_W-1:0] loc;
  logic             loc_ok, byte_ev;
  logic [BYTE_W-1:0] stg_lo, stg_hi;

  assign dest    = addr[LOC_W+SEL_W-1:LOC_W];
  assign loc     = addr[LOC_W-1:0];
  assign loc_ok  = (loc < LOC_W'(NUM_LOC));
  assign byte_ev = ~busy & ~ld_sel_n &
                   (((mode == LM_PARALLEL) & ~wr_n) | ((mode == LM_PROC) & stb_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_lo <= '0;
      stg_hi <= '0;
    end else if (busy) begin
      stg_lo <= '0;
      stg_hi <= '0;
    end else if (byte_ev) begin
      if (dest == SEL_STG_LO) stg_lo <= din;
      if (dest == SEL_STG_HI) stg_hi <= din;
    end
  end

  // serial path
  logic                ser_bit_ev, ser_vld, ser_done;
  logic [WORD_W-1:0]   ser_word;
  logic [BANK_W-1:0]   ser_bank;
  logic [LOC_W-1:0]    ser_loc;

  assign ser_bit_ev = ~busy & ~ld_sel_n & (mode == LM_SERIAL) & stb_fall & ~ser_done;

  coef_ld_serial #(.NUM_BANK(NUM_BANK), .NUM_LOC(NUM_LOC), .WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .clr(busy), .bit_en(ser_bit_ev), .bit_in(din[BYTE_W-1]),
    .word_vld(ser_vld), .word(ser_word), .bank(ser_bank), .loc(ser_loc), .done(ser_done)
  );

  // bank enable decode
  logic [NUM_BANK-1:0] byte_hit, ser_oh, we_nx;
  for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
    assign byte_hit[g] = byte_ev & loc_ok & (dest == SEL_W'(g));
    assign ser_oh[g]   = ser_vld & (ser_bank == BANK_W'(g));
  end
  assign we_nx = ser_vld ? ser_oh : byte_hit;

  logic run_nx;
  always_comb begin
    unique case (mode)
      LM_SERIAL:   run_nx = ser_done;
      LM_PARALLEL: run_nx = wr_n | ld_sel_n;
      LM_PROC:     run_nx = ld_sel_n;
      default:     run_nx = 1'b0;
    endcase
    if (cfg_hold) run_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      run_en    <= 1'b0;
    end else begin
      mem_we <= we_nx;
      run_en <= run_nx;
      if (|we_nx) begin
        mem_addr  <= ser_vld ? ser_loc  : loc;
        mem_wdata <= ser_vld ? ser_word : {din, stg_hi, stg_lo};
      end
    end
  end

  assign serial_done = ser_done;

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_we)); // R3
  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hold |=> (mem_we == '0 && !run_en)); // R1
  AST_LOC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != '0) |-> (mem_addr < LOC_W'(NUM_LOC))); // R4
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LM_RSVD) |=> (mem_we == '0 && !run_en)); // R9
  AST_PAR_LOAD_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LM_PARALLEL && !wr_n && !ld_sel_n) |=> !run_en); // R6
  AST_SER_DONE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LM_SERIAL && serial_done && !cfg_hold) |=> run_en); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LM_PROC && stb_fall) |=> !stb_fall); // R5
endmodule

// File: tb/tb_coef_loader.sv
module tb_coef_loader;
  localparam int NB = 6;
  localparam int NL = 108;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, cfg_hold, ld_sel_n, wr_n;
  logic [7:0]  din;
  logic [9:0]  addr;
  logic [5:0]  mem_we;
  logic [6:0]  mem_addr;
  logic [23:0] mem_wdata;
  logic        run_en, serial_done;

  coef_loader dut (
    .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .ld_sel_n(ld_sel_n), .wr_n(wr_n),
    .din(din), .addr(addr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .run_en(run_en), .serial_done(serial_done)
  );

  typedef struct packed {
    logic [2:0]  bank;
    logic [6:0]  loc;
    logic [23:0] data;
  } wr_t;

  wr_t   exp_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string cur_req = "R1";
  logic [23:0] ram [NB][NL];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // RAM model fed by the write stream
  always @(posedge clk) begin
    for (int b = 0; b < NB; b++)
      if (mem_we[b] && mem_addr < NL) ram[b][mem_addr] <= mem_wdata;
  end

  // monitor: compare every write pulse with the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_we != '0) begin
      wr_t got, exp;
      logic [2:0] bidx;
      bidx = '0;
      for (int b = 0; b < NB; b++) if (mem_we[b]) bidx = 3'(b);
      got = '{bank: bidx, loc: mem_addr, data: mem_wdata};
      check($countones(mem_we) == 1, "R3", "enable not one-hot", 40'(mem_we), 40'(1) << bidx);
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, "unexpected write", 40'(got), 40'(0));
      end else begin
        exp = exp_q.pop_front();
        check(got == exp, cur_req, "write bank/loc/data", 40'(got), 40'(exp));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int b, input int l, input logic [23:0] d);
    exp_q.push_back('{bank: 3'(b), loc: 7'(l), data: d});
  endtask

  task automatic configure(input logic [6:0] w);
    cfg_hold = 1'b1; wr_n = 1'b1; din = {1'b0, w};
    tick(2);
    cfg_hold = 1'b0;
    tick(2);
  endtask

  task automatic proc_write(input logic [9:0] a, input logic [7:0] d, input int hold);
    addr = a; din = d; tick(1);
    wr_n = 1'b0; tick(hold);
    wr_n = 1'b1; tick(3);
  endtask

  task automatic ser_bit(input logic b);
    din = {b, 7'h0};
    wr_n = 1'b0; tick(2);
    wr_n = 1'b1; tick(2);
  endtask

  function automatic logic [23:0] sw(input int b, input int l);
    return 24'((b * 7919 + l * 104729) ^ 24'hA5C3E1);
  endfunction

  function automatic logic [9:0] ba(input int sel, input int l);
    return {3'(sel), 7'(l)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_hold = 1'b0; ld_sel_n = 1'b1; wr_n = 1'b1; din = '0; addr = '0;
    tick(3);
    check(mem_we == '0, "R1", "reset mem_we", 40'(mem_we), 0);
    check(run_en == 1'b0, "R1", "reset run_en", 40'(run_en), 0);
    check(serial_done == 1'b0, "R1", "reset serial_done", 40'(serial_done), 0);
    rst_n = 1'b1; tick(2);

    // parallel mode
    configure(7'h20);
    check(run_en == 1'b1, "R6", "parallel idle run_en", 40'(run_en), 1);
    cur_req = "R2";
    push(0, 0, 24'hFB2EF4);
    push(5, 107, 24'h11DDCC);
    push(1, 9, 24'h42DDCC);
    ld_sel_n = 1'b0; wr_n = 1'b0;
    addr = 10'h300; din = 8'hF4; tick(1);
    addr = 10'h380; din = 8'h2E; tick(1);
    check(run_en == 1'b0, "R6", "parallel loading run_en", 40'(run_en), 0);
    addr = 10'h000; din = 8'hFB; tick(1);
    addr = 10'h36B; din = 8'hCC; tick(1);
    addr = 10'h3EB; din = 8'hDD; tick(1);
    addr = 10'h2EB; din = 8'h11; tick(1);
    cur_req = "R4";
    addr = ba(2, 108); din = 8'h55; tick(1);
    addr = ba(4, 127); din = 8'h56; tick(1);
    cur_req = "R3";
    addr = ba(1, 9); din = 8'h42; tick(1);
    wr_n = 1'b1; tick(4);
    check(exp_q.size() == 0, "R2", "parallel writes outstanding", 40'(exp_q.size()), 0);
    check(ram[0][0] == 24'hFB2EF4, "R3", "bank0 loc0", 40'(ram[0][0]), 40'h FB2EF4);
    check(ram[5][107] == 24'h11DDCC, "R3", "bank5 loc107", 40'(ram[5][107]), 40'h11DDCC);

    // configure clears staging
    configure(7'h20);
    cur_req = "R1";
    push(3, 3, 24'h770000);
    wr_n = 1'b0; addr = ba(3, 3); din = 8'h77; tick(1);
    wr_n = 1'b1; tick(4);
    check(exp_q.size() == 0, "R1", "staging-cleared write missing", 40'(exp_q.size()), 0);

    // reserved mode
    configure(7'h60);
    cur_req = "R9";
    wr_n = 1'b0;
    addr = 10'h300; din = 8'h01; tick(1);
    addr = ba(0, 5); din = 8'h02; tick(1);
    check(run_en == 1'b0, "R9", "reserved run_en", 40'(run_en), 0);
    wr_n = 1'b1; tick(4);
    check(run_en == 1'b0, "R9", "reserved idle run_en", 40'(run_en), 0);

    // processor mode
    configure(7'h40);
    ld_sel_n = 1'b1; tick(2);
    check(run_en == 1'b1, "R6", "processor deselected run_en", 40'(run_en), 1);
    ld_sel_n = 1'b0; tick(2);
    check(run_en == 1'b0, "R6", "processor selected run_en", 40'(run_en), 0);
    cur_req = "R5";
    push(2, 50, 24'h9E5D3C);
    proc_write(10'h300, 8'h3C, 6);
    proc_write(10'h380, 8'h5D, 2);
    proc_write(ba(2, 50), 8'h9E, 7);
    check(exp_q.size() == 0, "R5", "processor write outstanding", 40'(exp_q.size()), 0);
    ld_sel_n = 1'b1;
    proc_write(10'h300, 8'hEE, 3);
    ld_sel_n = 1'b0;
    push(4, 0, 24'h815D3C);
    proc_write(ba(4, 0), 8'h81, 3);
    tick(2);
    check(ram[4][0] == 24'h815D3C, "R5", "deselected strobe ignored", 40'(ram[4][0]), 40'h815D3C);
    check(ram[2][50] == 24'h9E5D3C, "R5", "processor bank2 loc50", 40'(ram[2][50]), 40'h9E5D3C);

    // serial mode
    configure(7'h03);
    check(run_en == 1'b0, "R6", "serial start run_en", 40'(run_en), 0);
    check(serial_done == 1'b0, "R8", "serial start done", 40'(serial_done), 0);
    cur_req = "R7";
    ld_sel_n = 1'b1;
    ser_bit(1'b1); ser_bit(1'b1); ser_bit(1'b0);
    ld_sel_n = 1'b0;
    for (int b = 0; b < NB; b++) begin
      for (int l = 0; l < NL; l++) begin
        logic [23:0] w;
        w = sw(b, l);
        push(b, l, w);
        for (int k = 23; k >= 0; k--) ser_bit(w[k]);
        if (b == NB - 1 && l == NL - 2)
          check(serial_done == 1'b0, "R8", "done before last word", 40'(serial_done), 0);
      end
    end
    tick(4);
    check(exp_q.size() == 0, "R7", "serial writes outstanding", 40'(exp_q.size()), 0);
    check(serial_done == 1'b1, "R8", "serial done", 40'(serial_done), 1);
    check(run_en == 1'b1, "R8", "serial run_en", 40'(run_en), 1);
    cur_req = "R8";
    for (int k = 0; k < 30; k++) ser_bit(1'b1);
    check(serial_done == 1'b1, "R8", "done held", 40'(serial_done), 1);
    check(ram[0][0] == sw(0, 0), "R7", "serial bank0 loc0", 40'(ram[0][0]), 40'(sw(0, 0)));
    check(ram[5][107] == sw(5, 107), "R7", "serial bank5 loc107", 40'(ram[5][107]), 40'(sw(5, 107)));
    check(ram[3][77] == sw(3, 77), "R7", "serial bank3 loc77", 40'(ram[3][77]), 40'(sw(3, 77)));

    cfg_hold = 1'b1; tick(2);
    check(run_en == 1'b0, "R1", "run_en during hold", 40'(run_en), 0);
    check(serial_done == 1'b0, "R1", "done cleared by hold", 40'(serial_done), 0);
    cfg_hold = 1'b0; tick(2);

    finished = 1;
    report();
    $finish;
  end
endmodule